// File: doc/BRIEF.md
# Event Counter Bank with Global Overflow Status

A bank of up-counting event counters placed behind a simple register port. Each counter counts cycles in which its own event input is high, provided both a per-counter local enable and the matching bit of a shared gate register are set. Writing the gate register once starts or stops any chosen subset of counters on the same clock edge, so counters watching the same event stay in step.

Software arms a counter by loading a value with its most significant bit set, which stands for a negative distance to overflow. When the counter wraps from all ones to zero, its bit in an overflow status register is latched. That status register cannot be written. Overflows are acknowledged only through a separate clear register, in which each 1 clears the bit with the same index. A level interrupt is driven while any latched overflow has its interrupt enable set. Nothing is masked automatically when the interrupt fires, so later overflows raise it again without any re-enable step.

Register map (word addresses on `bus_addr`): 0 to NUM_CTR-1 hold the counter values (read/write, zero-extended on read), 0x10 holds the gate mask (read/write), 0x11 holds the overflow status (read only), 0x12 is the overflow clear (write only, reads 0), 0x13 holds the local enable mask and 0x14 holds the interrupt enable mask. In every mask, bit i belongs to counter i. Reads are combinational from `bus_addr`; writes take effect at the clock edge on which `bus_wr` is high.

Top module: `pmu_bank`

## Requirements
- R1: After reset every counter reads 0, the gate, local enable, interrupt enable and status registers read 0, and `irq` is low.
- R2: Counter i increases by exactly one on each clock edge at which gate bit i, local enable bit i and `evt_in[i]` are all 1. In any other cycle without a load, it holds its value.
- R3: A write to the status address (0x11) leaves every overflow bit unchanged.
- R4: Writing the clear register (0x12) clears status bit i for each data bit i that is 1, and leaves the status bits whose data bits are 0 unchanged.
- R5: Data bits at positions NUM_CTR and above in a clear write have no effect on status, and status bits at those positions read as 0.
- R6: A single gate write starts or stops all selected counters on the same edge, so two counters on the same event read equal values.
- R7: When counter i steps from all ones to zero, status bit i is set on that same edge. A counter loaded with its top bit set has overflowed once its top bit reads 0.
- R8: `irq` is high exactly while some status bit i and interrupt enable bit i are both 1. It stays high until the bits are cleared and rises again on a later overflow without any re-enable write.
- R9: If counter i wraps on the same edge at which the clear register clears bit i, status bit i ends up set.
- R10: A write to a counter value register loads that counter but does not change its status bit.
- R11: A counter write takes priority over an increment on the same edge, so the counter then reads the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| evt_in | input | NUM_CTR | Event input, one per counter |
| irq | output | 1 | Level overflow interrupt |

## Verification
Counting is tried with patterns that clear each of gate, local enable and event in turn, plus mixed masks where the three differ bit by bit. These separate a counter that uses all three qualifiers from one that ignores any of them or takes them from the wrong index. Overflow is driven from a loaded value just below wrap so that the edge before the wrap and the wrap edge itself can be told apart. Clear writes carry only high-order bits, single low bits, and a clear that coincides with a wrap. These separate true write-one-to-clear from a plain write, from masking errors and from a lost overflow.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_GATE = 5'h10;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h11;
    localparam logic [ADDR_W-1:0] A_CLR  = 5'h12;
    localparam logic [ADDR_W-1:0] A_LEN  = 5'h13;
    localparam logic [ADDR_W-1:0] A_IEN  = 5'h14;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTR,
        REG_GATE,
        REG_STAT,
        REG_CLR,
        REG_LEN,
        REG_IEN
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a, input int n);
        if (int'(a) < n)    return REG_CTR;
        else if (a == A_GATE) return REG_GATE;
        else if (a == A_STAT) return REG_STAT;
        else if (a == A_CLR)  return REG_CLR;
        else if (a == A_LEN)  return REG_LEN;
        else if (a == A_IEN)  return REG_IEN;
        else                  return REG_NONE;
    endfunction

endpackage

// File: rtl/pmu_ctl_regs.sv
module pmu_ctl_regs
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [NUM_CTR-1:0] gate,
    output logic [NUM_CTR-1:0] len,
    output logic [NUM_CTR-1:0] ien,
    output logic [NUM_CTR-1:0] clr_bits,
    output logic [NUM_CTR-1:0] ld_sel
);

    reg_sel_e sel;

    assign sel = decode(bus_addr, NUM_CTR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= '0;
            len  <= '0;
            ien  <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_GATE: gate <= bus_wdata[NUM_CTR-1:0];
                REG_LEN:  len  <= bus_wdata[NUM_CTR-1:0];
                REG_IEN:  ien  <= bus_wdata[NUM_CTR-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr_bits = '0;
        ld_sel   = '0;
        if (bus_wr) begin
            unique case (sel)
                REG_CLR: clr_bits = bus_wdata[NUM_CTR-1:0];
                REG_CTR: ld_sel[bus_addr[$clog2(NUM_CTR+1)-1:0]] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CTR_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             ld,
    input  logic [CTR_W-1:0] ld_val,
    output logic [CTR_W-1:0] value,
    output logic             wrap
);

    localparam logic [CTR_W-1:0] ALL_ONES = '1;

    assign wrap = cnt_en && !ld && (value == ALL_ONES);

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (ld)
            value <= ld_val;
        else if (cnt_en)
            value <= value + 1'b1;
    end

endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status #(
    parameter int NUM_CTR = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] wrap,
    input  logic [NUM_CTR-1:0] clr_bits,
    input  logic [NUM_CTR-1:0] ien,
    output logic [NUM_CTR-1:0] status,
    output logic               irq
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_bits) | wrap;
    end

    assign irq = |(status & ien);

endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_CTR-1:0] evt_in,
    output logic               irq
);

    logic [NUM_CTR-1:0]       gate, len, ien, clr_bits, ld_sel, wrap, status;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;

    pmu_ctl_regs #(.NUM_CTR(NUM_CTR), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .gate      (gate),
        .len       (len),
        .ien       (ien),
        .clr_bits  (clr_bits),
        .ld_sel    (ld_sel)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pmu_counter #(.CTR_W(CTR_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_en (gate[i] & len[i] & evt_in[i]),
            .ld     (ld_sel[i]),
            .ld_val (bus_wdata[CTR_W-1:0]),
            .value  (cnt_flat[i*CTR_W +: CTR_W]),
            .wrap   (wrap[i])
        );
    end

    pmu_ovf_status #(.NUM_CTR(NUM_CTR)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .clr_bits (clr_bits),
        .ien      (ien),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (decode(bus_addr, NUM_CTR))
            REG_CTR: begin
                for (int k = 0; k < NUM_CTR; k++)
                    if (int'(bus_addr) == k)
                        bus_rdata[CTR_W-1:0] = cnt_flat[k*CTR_W +: CTR_W];
            end
            REG_GATE: bus_rdata[NUM_CTR-1:0] = gate;
            REG_STAT: bus_rdata[NUM_CTR-1:0] = status;
            REG_LEN:  bus_rdata[NUM_CTR-1:0] = len;
            REG_IEN:  bus_rdata[NUM_CTR-1:0] = ien;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int DATA_W  = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [NUM_CTR-1:0]       gate,
    input logic [NUM_CTR-1:0]       len,
    input logic [NUM_CTR-1:0]       evt_in,
    input logic [NUM_CTR-1:0]       wrap,
    input logic [NUM_CTR-1:0]       status,
    input logic                     irq,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);

    // R3: status address writes do not alter overflow bits
    p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && wrap == '0) |=> $stable(status));

    // R8: interrupt level holds while no register is written
    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        // R2: a stopped counter holds
        p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!(gate[i] && len[i] && evt_in[i]) && !(bus_wr && int'(bus_addr) == i))
            |=> $stable(cnt_flat[i*CTR_W +: CTR_W]));

        // R7: a wrap latches the overflow bit
        p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> status[i]);

        // R4: a one in the clear register clears the bit when no wrap occurs
        p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_CLR && bus_wdata[i] && !wrap[i]) |=> !status[i]);

        // R10: loading a counter leaves its overflow bit alone
        p_load_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && int'(bus_addr) == i) |=> (status[i] == $past(status[i])));
    end

endmodule

bind pmu_bank pmu_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .gate      (gate),
    .len       (len),
    .evt_in    (evt_in),
    .wrap      (wrap),
    .status    (status),
    .irq       (irq),
    .cnt_flat  (cnt_flat)
);

// File: tb/sim_pmu_bank.sv
module sim_pmu_bank;

    localparam int N  = 6;
    localparam int W  = 48;
    localparam int DW = 64;
    localparam logic [4:0] A_GATE = 5'h10, A_STAT = 5'h11, A_CLR = 5'h12,
                           A_LEN  = 5'h13, A_IEN  = 5'h14;
    localparam logic [DW-1:0] MAXV = {16'h0, {W{1'b1}}};

    // gate, local enable, event, expected increment mask
    localparam logic [23:0] VEC [7] = '{
        {6'h3F, 6'h3F, 6'h3F, 6'h3F},
        {6'h00, 6'h3F, 6'h3F, 6'h00},
        {6'h3F, 6'h00, 6'h3F, 6'h00},
        {6'h3F, 6'h3F, 6'h00, 6'h00},
        {6'h15, 6'h3F, 6'h3F, 6'h15},
        {6'h3F, 6'h0F, 6'h33, 6'h03},
        {6'h2A, 6'h3E, 6'h2F, 6'h2A}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  evt_in = '0;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pmu_bank #(.NUM_CTR(N), .CTR_W(W), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m, input int n);
        @(negedge clk);
        evt_in = m;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [DW-1:0] e, input string tag);
        logic [DW-1:0] v;
        rd(a, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [DW-1:0] base [N];
        logic [DW-1:0] v, v2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < N; i++) expect_reg(5'(i), '0, "R1 counter");
        expect_reg(A_GATE, '0, "R1 gate");
        expect_reg(A_LEN,  '0, "R1 len");
        expect_reg(A_IEN,  '0, "R1 ien");
        expect_reg(A_STAT, '0, "R1 status");
        chk(irq == 1'b0, "R1 irq", 64'(irq), 0);

        // R2: table of qualifier patterns
        for (int r = 0; r < 7; r++) begin
            wr(A_LEN,  64'(VEC[r][17:12]));
            wr(A_GATE, 64'(VEC[r][23:18]));
            for (int i = 0; i < N; i++) rd(5'(i), base[i]);
            pulse(VEC[r][11:6], 3);
            for (int i = 0; i < N; i++)
                expect_reg(5'(i), base[i] + (VEC[r][i] ? 64'd3 : 64'd0), "R2 count");
        end
        wr(A_GATE, '0);
        wr(A_LEN, 64'h3F);

        // R11: load beats increment
        wr(A_GATE, 64'h1);
        @(negedge clk);
        evt_in = 6'h01; bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 64'd100;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        expect_reg(5'd0, 64'd100, "R11 load priority");

        // R7: wrap sets status on the wrap edge only
        wr(A_IEN, 64'h1);
        wr(5'd0, MAXV - 1);
        pulse(6'h01, 1);
        expect_reg(5'd0, MAXV, "R7 before wrap");
        expect_reg(A_STAT, '0, "R7 no early overflow");
        chk(irq == 1'b0, "R8 irq before wrap", 64'(irq), 0);
        pulse(6'h01, 1);
        rd(5'd0, v);
        chk(v[W-1] == 1'b0 && v == 0, "R7 top bit clear", v, 0);
        expect_reg(A_STAT, 64'h1, "R7 overflow bit0");
        chk(irq == 1'b1, "R8 irq raised", 64'(irq), 1);

        // R3: status not writable
        wr(A_STAT, 64'h0);
        expect_reg(A_STAT, 64'h1, "R3 status read only");

        // R5: high clear bits ignored
        wr(A_CLR, ~64'h3F);
        expect_reg(A_STAT, 64'h1, "R5 high clear bits");
        chk(irq == 1'b1, "R5 irq kept", 64'(irq), 1);

        // R10: counter load keeps status
        wr(5'd0, 64'd5);
        expect_reg(A_STAT, 64'h1, "R10 load keeps status");
        expect_reg(5'd0, 64'd5, "R10 loaded value");

        // R4: clear one bit, keep the other
        wr(A_GATE, 64'h3);
        wr(5'd1, MAXV);
        pulse(6'h02, 1);
        expect_reg(A_STAT, 64'h3, "R7 overflow bit1");
        wr(A_CLR, 64'h2);
        expect_reg(A_STAT, 64'h1, "R4 clear bit1 only");
        wr(A_CLR, 64'h1);
        expect_reg(A_STAT, 64'h0, "R4 clear bit0");
        chk(irq == 1'b0, "R8 irq drops", 64'(irq), 0);

        // R8: interrupt enable gating and relive without unmask
        wr(5'd1, MAXV);
        pulse(6'h02, 1);
        expect_reg(A_STAT, 64'h2, "R8 bit1 latched");
        chk(irq == 1'b0, "R8 masked by ien", 64'(irq), 0);
        wr(A_CLR, 64'h3F);
        wr(5'd0, MAXV);
        pulse(6'h01, 1);
        chk(irq == 1'b1, "R8 second overflow", 64'(irq), 1);
        wr(A_CLR, 64'h3F);

        // R9: wrap and clear on same edge
        wr(5'd0, MAXV);
        @(negedge clk);
        evt_in = 6'h01; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 64'h1;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        expect_reg(A_STAT, 64'h1, "R9 set wins");
        wr(A_CLR, 64'h3F);

        // R6: common start and stop
        wr(A_GATE, '0);
        wr(5'd2, '0);
        wr(5'd3, '0);
        @(negedge clk);
        evt_in = 6'h0C;
        wr(A_GATE, 64'h0C);
        repeat (5) @(negedge clk);
        wr(A_GATE, '0);
        evt_in = '0;
        rd(5'd2, v);
        rd(5'd3, v2);
        chk(v == v2, "R6 counters in step", v2, v);
        chk(v == 64'd7, "R6 count window", v, 7);

        done = 1'b1;
        report();
    end

endmodule